// File: doc/BRIEF.md
# Read Reply Turnaround Sequencer

This block times the bus turnaround and the reply phase of a register read on a shared, half-duplex, serial control line. The chip's deserializer pulses `start_i` in the cycle whose closing clock edge ends the stop bit of the last address character of a read. That edge is edge 0 of a fixed 65-edge schedule. From edge 0 the sequencer counts clock edges. It tells the line receiver when to stop and when to resume sampling. It tells the line driver when this chip owns the line. It tells the serializer when to launch the three reply characters.

The reply is made of three bytes. The first is the chip's own identifier, which serves as the acknowledge. The second and third are the low and high bytes of the data word that was read. The sequencer captures these bytes at edge 0 and presents them unchanged for the rest of the schedule. Serial encoding, start and stop bits, and the line driver itself belong to other blocks. If the read targets a broadcast or multicast identifier, or any other chip, the sequencer never drives the line. It still silences its receiver for the turnaround, because the line does not carry master traffic during that time.

Top module: `rd_turnaround_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, `sample_en_o` is 1, `drive_en_o` and `launch_o` are 0, and all three reply bytes are 0.
- R2: For every accepted read, addressed here or not, `sample_en_o` is 0 from edge 0 until edge 60. It returns to 1 after edge 60. Edge k is the k-th rising clock edge after the edge at which `start_i` is sampled high, and that sampling edge is edge 0.
- R3: For a read addressed to this chip, `drive_en_o` is 1 from edge 7 until edge 55 and 0 at all other times. `drive_en_o` is never 1 while `sample_en_o` is 1.
- R4: A read counts as addressed to this chip only when `tgt_id_i` equals `{1'b0, own_id_i}` and `own_id_i[2:0]` is not 3'b111. The codes 8'h0F (global broadcast) and any value whose low three bits are 111 never enable the driver.
- R5: For a read addressed to this chip, `launch_o` is high for exactly one cycle, the one following edge 15. For any other read it stays 0.
- R6: At edge 0 the sequencer captures `ack_byte_o = {1'b0, own_id_i}`, `lo_byte_o = rd_data_i[7:0]` and `hi_byte_o = rd_data_i[15:8]`. These values then hold until the next accepted start.
- R7: A `start_i` pulse sampled at edges 0 to 64 of a running schedule is ignored. Outputs and captured bytes follow the running schedule.
- R8: A `start_i` sampled at edge 65 of a running schedule is accepted, and that edge becomes edge 0 of a new schedule.
- R9: After edge 65, when no new start is accepted, the block is idle: `sample_en_o` is 1 and `drive_en_o` and `launch_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the control line |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | High in the cycle whose closing edge ends the last address stop bit of a read |
| tgt_id_i | input | 8 | Chip identifier character of the read |
| own_id_i | input | 7 | This chip's identifier |
| rd_data_i | input | 16 | Register data to return, valid with `start_i` |
| sample_en_o | output | 1 | Receiver may sample the line |
| drive_en_o | output | 1 | This chip's line driver is enabled (idle or data) |
| launch_o | output | 1 | One-cycle strobe that starts the serializer |
| ack_byte_o | output | 8 | First reply character: own identifier |
| lo_byte_o | output | 8 | Second reply character: low data byte |
| hi_byte_o | output | 8 | Third reply character: high data byte |

## Verification
The hardest conditions to reach from the ports are the edges of a running schedule. One is a start arriving exactly at edge 65, which must be accepted. The other is a start arriving at edge 64 or earlier, which must be ignored. The bench pulses `start_i` at a chosen edge inside its transaction loop, with deliberately different target and data values. This shows that a rejected start changes neither the outputs nor the captured bytes. Back-to-back transactions start with zero gap, and random gaps cover the idle state in between. Random own identifiers, including reserved low-bit patterns, and targets set to the own ID, the broadcast code or a multicast code exercise the address-match rule.

// File: rtl/rts_pkg.sv
// Shared types for the read reply turnaround sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rts_pkg;
    // Named slices of the 65-edge turnaround schedule
    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,
        PH_MIDLE   = 3'd1,
        PH_TURN1   = 3'd2,
        PH_SIDLE   = 3'd3,
        PH_REPLY   = 3'd4,
        PH_SIDLE2  = 3'd5,
        PH_TURN2   = 3'd6,
        PH_MIDLE2  = 3'd7
    } phase_e;
endpackage

// File: rtl/rts_timer.sv
// Edge counter of the turnaround schedule.
// After the edge that accepts a start, cnt_o reads 0. After edge k it reads k.
// The schedule ends at edge DONE_EDGE. A start is accepted when idle, or in
// the last cycle so that a new schedule begins exactly at DONE_EDGE.
// Assumes: start_i is synchronous to clk.
module rts_timer #(
    parameter int DONE_EDGE = 65,
    localparam int CW = $clog2(DONE_EDGE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          active_o,
    output logic [CW-1:0] cnt_o,
    output logic          accept_o
);
    localparam logic [CW-1:0] LAST = CW'(DONE_EDGE - 1);

    logic last_cycle;

    // Final cycle of a running schedule
    assign last_cycle = active_o && (cnt_o == LAST);
    // Start acceptance: idle or at the closing edge
    assign accept_o = start_i && (!active_o || last_cycle);

    // Count edges while a schedule runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
        end else if (accept_o) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
        end else if (last_cycle) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
        end else if (active_o) begin
            cnt_o    <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/rts_payload.sv
// Captures the address-match result and the three reply bytes when a
// start is accepted, and holds them until the next accepted start.
// Assumes: tgt_id_i, own_id_i and rd_data_i are valid with start.
module rts_payload #(
    parameter int ID_W   = 7,
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [BYTE_W-1:0] tgt_id_i,
    input  logic [ID_W-1:0]   own_id_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              hit_o,
    output logic [BYTE_W-1:0] ack_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o
);
    logic [BYTE_W-1:0] own_char;
    logic              own_legal;
    logic              match;

    // Own identifier as it appears on the line
    assign own_char  = BYTE_W'(own_id_i);
    // Low three bits all ones are reserved for group addressing
    assign own_legal = (own_id_i[2:0] != 3'b111);
    // Unicast match only
    assign match     = own_legal && (tgt_id_i == own_char);

    // Latch match and reply bytes at edge 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o <= 1'b0;
            ack_o <= '0;
            lo_o  <= '0;
            hi_o  <= '0;
        end else if (accept_i) begin
            hit_o <= match;
            ack_o <= own_char;
            lo_o  <= rd_data_i[BYTE_W-1:0];
            hi_o  <= rd_data_i[DATA_W-1:BYTE_W];
        end
    end
endmodule

// File: rtl/rts_decode.sv
// Maps the edge count to the schedule phase and the line-control outputs.
// Sampling is off from edge 0 to SAMPLE_EDGE. The driver is on from
// DRV_ON_EDGE to DRV_OFF_EDGE, and the launch strobe fires after
// LAUNCH_EDGE; both happen only when the read matched.
// Assumes: cnt_i counts edges since edge 0 while active_i is high.
module rts_decode
    import rts_pkg::*;
#(
    parameter int DRV_ON_EDGE  = 7,
    parameter int LAUNCH_EDGE  = 15,
    parameter int DRV_OFF_EDGE = 55,
    parameter int SAMPLE_EDGE  = 60,
    parameter int DONE_EDGE    = 65,
    localparam int CW = $clog2(DONE_EDGE + 1)
) (
    input  logic          active_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          hit_i,
    output phase_e        phase_o,
    output logic          sample_en_o,
    output logic          drive_en_o,
    output logic          launch_o
);
    localparam int TURN1_EDGE  = 5;
    localparam int SIDLE_EDGE  = 10;
    localparam int REPLY_END   = 50;

    int unsigned c;

    // Classify the current cycle into a phase
    always_comb begin
        c = int'(cnt_i);
        if (!active_i)                 phase_o = PH_OFF;
        else if (c < TURN1_EDGE)       phase_o = PH_MIDLE;
        else if (c < SIDLE_EDGE)       phase_o = PH_TURN1;
        else if (c < LAUNCH_EDGE)      phase_o = PH_SIDLE;
        else if (c < REPLY_END)        phase_o = PH_REPLY;
        else if (c < DRV_OFF_EDGE)     phase_o = PH_SIDLE2;
        else if (c < SAMPLE_EDGE)      phase_o = PH_TURN2;
        else                           phase_o = PH_MIDLE2;
    end

    // Drive the line-control outputs from phase and count
    always_comb begin
        sample_en_o = !active_i || (int'(cnt_i) >= SAMPLE_EDGE);
        drive_en_o  = active_i && hit_i &&
                      (int'(cnt_i) >= DRV_ON_EDGE) && (int'(cnt_i) < DRV_OFF_EDGE);
        launch_o    = active_i && hit_i && (int'(cnt_i) == LAUNCH_EDGE);
    end
endmodule

// File: rtl/rd_turnaround_seq.sv
// Top of the read reply turnaround sequencer. Times the receiver, the line
// driver and the serializer launch across a 65-edge read turnaround, and
// presents the three reply bytes.
// Assumes: start_i is high in the cycle whose closing edge ends the final
// address stop bit of a read, and identifier and data are valid with it.
module rd_turnaround_seq
    import rts_pkg::*;
#(
    parameter int ID_W         = 7,
    parameter int BYTE_W       = 8,
    parameter int DRV_ON_EDGE  = 7,
    parameter int LAUNCH_EDGE  = 15,
    parameter int DRV_OFF_EDGE = 55,
    parameter int SAMPLE_EDGE  = 60,
    parameter int DONE_EDGE    = 65,
    localparam int DATA_W = 2 * BYTE_W,
    localparam int CW     = $clog2(DONE_EDGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] tgt_id_i,
    input  logic [ID_W-1:0]   own_id_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sample_en_o,
    output logic              drive_en_o,
    output logic              launch_o,
    output logic [BYTE_W-1:0] ack_byte_o,
    output logic [BYTE_W-1:0] lo_byte_o,
    output logic [BYTE_W-1:0] hi_byte_o
);
    logic          active;
    logic [CW-1:0] cnt;
    logic          accept;
    logic          hit;
    phase_e        phase;

    rts_timer #(.DONE_EDGE(DONE_EDGE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .active_o (active),
        .cnt_o    (cnt),
        .accept_o (accept)
    );

    rts_payload #(.ID_W(ID_W), .BYTE_W(BYTE_W)) u_payload (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .tgt_id_i  (tgt_id_i),
        .own_id_i  (own_id_i),
        .rd_data_i (rd_data_i),
        .hit_o     (hit),
        .ack_o     (ack_byte_o),
        .lo_o      (lo_byte_o),
        .hi_o      (hi_byte_o)
    );

    rts_decode #(
        .DRV_ON_EDGE  (DRV_ON_EDGE),
        .LAUNCH_EDGE  (LAUNCH_EDGE),
        .DRV_OFF_EDGE (DRV_OFF_EDGE),
        .SAMPLE_EDGE  (SAMPLE_EDGE),
        .DONE_EDGE    (DONE_EDGE)
    ) u_decode (
        .active_i    (active),
        .cnt_i       (cnt),
        .hit_i       (hit),
        .phase_o     (phase),
        .sample_en_o (sample_en_o),
        .drive_en_o  (drive_en_o),
        .launch_o    (launch_o)
    );
endmodule

// File: rtl/rd_turnaround_seq_chk.sv
// Temporal checks on the sequencer's ports, bound to every instance.
// Assumes: rst_n is synchronous and active low.
module rd_turnaround_seq_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en_o,
    input logic              drive_en_o,
    input logic              launch_o,
    input logic [BYTE_W-1:0] ack_byte_o,
    input logic [BYTE_W-1:0] lo_byte_o,
    input logic [BYTE_W-1:0] hi_byte_o
);
    // R3: the chip never drives and samples the line together
    p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_o |-> !sample_en_o);

    // R3: the driver turns on only after sampling was already off
    p_drive_after_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en_o) |-> $past(!sample_en_o));

    // R5: launch happens with the driver on
    p_launch_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> drive_en_o);

    // R5: launch is a single-cycle strobe
    p_launch_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !launch_o);

    // R6: reply bytes hold steady while the driver is on
    p_bytes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && $past(drive_en_o)) |-> $stable({ack_byte_o, lo_byte_o, hi_byte_o}));

    // R2: sampling resumes only after the driver has been off for a cycle
    p_resume_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_en_o) |-> (!drive_en_o && $past(!drive_en_o)));
endmodule

bind rd_turnaround_seq rd_turnaround_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en_o (sample_en_o),
    .drive_en_o  (drive_en_o),
    .launch_o    (launch_o),
    .ack_byte_o  (ack_byte_o),
    .lo_byte_o   (lo_byte_o),
    .hi_byte_o   (hi_byte_o)
);

// File: tb/rd_turnaround_seq_test.sv
module rd_turnaround_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  tgt_id_i = '0;
    logic [6:0]  own_id_i = '0;
    logic [15:0] rd_data_i = '0;
    logic        sample_en_o, drive_en_o, launch_o;
    logic [7:0]  ack_byte_o, lo_byte_o, hi_byte_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_turnaround_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tgt_id_i(tgt_id_i), .own_id_i(own_id_i), .rd_data_i(rd_data_i),
        .sample_en_o(sample_en_o), .drive_en_o(drive_en_o), .launch_o(launch_o),
        .ack_byte_o(ack_byte_o), .lo_byte_o(lo_byte_o), .hi_byte_o(hi_byte_o)
    );

    // Address rule of R4, computed independently
    function automatic bit exp_hit(logic [7:0] tgt, logic [6:0] own);
        return (tgt == {1'b0, own}) && (own[2:0] != 3'b111);
    endfunction

    function automatic bit exp_sample(int k);
        return k >= 60;
    endfunction

    function automatic bit exp_drive(int k, bit hit);
        return hit && k >= 7 && k < 55;
    endfunction

    function automatic bit exp_launch(int k, bit hit);
        return hit && k == 15;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One read: start sampled at edge 0. The k loop checks after each edge.
    // A second start pulse at edge xk (if 1..64) must be ignored (R7).
    // Leaves the bench at the negedge after edge 64.
    task automatic txn(logic [7:0] tgt, logic [6:0] own, logic [15:0] data, int xk);
        bit hit = exp_hit(tgt, own);
        tgt_id_i  = tgt;
        own_id_i  = own;
        rd_data_i = data;
        start_i   = 1'b1;
        for (int k = 0; k <= 64; k++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = (k + 1 == xk);
            if (k + 1 == xk) begin
                tgt_id_i  = {1'b0, own};
                own_id_i  = own ^ 7'h11;
                rd_data_i = ~data;
            end else begin
                tgt_id_i  = $urandom;
                rd_data_i = $urandom;
            end
            chk("R2 sample_en", 32'(sample_en_o), 32'(exp_sample(k)));
            chk(hit ? "R3 drive_en" : "R4 drive_en", 32'(drive_en_o), 32'(exp_drive(k, hit)));
            chk("R5 launch", 32'(launch_o), 32'(exp_launch(k, hit)));
            if (k == 15 || k == 50 || k == 64) begin
                chk("R6 ack byte", 32'(ack_byte_o), 32'({1'b0, own}));
                chk("R6 lo byte", 32'(lo_byte_o), 32'(data[7:0]));
                chk("R6 hi byte", 32'(hi_byte_o), 32'(data[15:8]));
            end
            if (xk > 0 && k == 64)
                chk("R7 schedule kept", 32'(sample_en_o), 32'(1));
        end
        own_id_i = own;
    endtask

    // Idle cycles after a schedule
    task automatic idle(int n);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9 idle sample", 32'(sample_en_o), 32'(1));
            chk("R9 idle drive", 32'(drive_en_o), 32'(0));
            chk("R9 idle launch", 32'(launch_o), 32'(0));
        end
    endtask

    initial begin
        logic [6:0] own;
        logic [7:0] tgt;
        int sel;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 sample", 32'(sample_en_o), 32'(1));
        chk("R1 drive", 32'(drive_en_o), 32'(0));
        chk("R1 launch", 32'(launch_o), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bytes", 32'({ack_byte_o, lo_byte_o, hi_byte_o}), 32'(0));
        chk("R1 sample after", 32'(sample_en_o), 32'(1));

        // Directed: matching unicast read
        txn(8'h23, 7'h23, 16'hBEEF, 0);
        idle(2);
        // Directed: global broadcast, other chip, multicast
        txn(8'h0F, 7'h0F, 16'h1234, 0);
        idle(1);
        txn(8'h24, 7'h23, 16'h5678, 0);
        idle(1);
        txn(8'h37, 7'h37, 16'h9ABC, 0);
        idle(1);
        // Directed: start inside the running schedule is ignored (R7)
        txn(8'h41, 7'h41, 16'hA55A, 31);
        idle(1);
        txn(8'h42, 7'h42, 16'h0F0F, 64);
        // Directed: back-to-back at edge 65 is accepted (R8)
        txn(8'h15, 7'h15, 16'hC3C3, 0);
        chk("R8 back-to-back", 32'(sample_en_o), 32'(1));
        txn(8'h16, 7'h16, 16'h3C3C, 0);
        idle(2);

        // Random mix
        for (int n = 0; n < 24; n++) begin
            own = $urandom;
            sel = $urandom_range(0, 3);
            case (sel)
                0, 1: tgt = {1'b0, own};
                2:    tgt = 8'h0F;
                default: tgt = {1'b0, own[6:3], 3'b111};
            endcase
            txn(tgt, own, 16'($urandom), ($urandom_range(0, 3) == 0) ? $urandom_range(1, 64) : 0);
            idle($urandom_range(0, 4));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule